// File: doc/BRIEF.md
# Issue Window Tag Wakeup

This block keeps a small pool of instructions that wait for their source operands inside an out-of-order core. Each slot records two physical source tags and one ready flag for each. Every cycle, the execution side broadcasts up to IW result tags, each with its own valid bit. Every slot compares both of its source tags against every broadcast tag. The comparator outputs for each operand are ORed, and a hit marks that operand ready.

A slot raises its issue request when it holds an instruction and both operands are ready. A hit in the current cycle already counts. This means a consumer can ask for issue in the same cycle its producer's tag appears, and the external selector can grant it then. Dispatch places up to IW new instructions per cycle into the lowest-numbered empty slots. A grant from the selector empties the slot at the next clock edge. Operand data, execution units and bypass paths lie outside this block.

Top module: `wk_window`

## Requirements
- R1: After reset no slot holds an instruction, `issue_req` is all zero and `disp_full` is low.
- R2: Slot i raises `issue_req[i]` exactly when it holds an instruction and both of its operands are ready. An operand is ready if it was flagged ready at dispatch, or woken earlier, or matched in the current cycle.
- R3: A broadcast tag that matches a waiting operand makes that operand count as ready in the same cycle. The operand stays ready in all later cycles.
- R4: A broadcast lane whose valid bit is low never wakes any operand, even when its tag value equals a waiting source tag.
- R5: Any broadcast lane can wake either operand of any slot. One tag can wake both operands of a slot in the same cycle.
- R6: Dispatch lane k (lane 0 in the lowest bits of the packed tag buses) targets the k-th lowest-numbered empty slot. A lane whose valid bit is low leaves its target slot empty. Other lanes keep their own targets.
- R7: The ready flags of a newly dispatched instruction include any match against the broadcast tags of its dispatch cycle.
- R8: A newly dispatched instruction does not request in its dispatch cycle. It can request from the following cycle on.
- R9: A grant on slot i empties the slot at the next edge, so `issue_req[i]` is low in the next cycle and the slot can be filled again.
- R10: `disp_full` is high whenever fewer than IW slots are empty. While it is high, every dispatch lane is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | IW | Dispatch lane valid bits |
| disp_src_a | input | IW*TAGW | First source tag per dispatch lane |
| disp_src_b | input | IW*TAGW | Second source tag per dispatch lane |
| disp_rdy_a | input | IW | First operand already ready, per lane |
| disp_rdy_b | input | IW | Second operand already ready, per lane |
| disp_full | output | 1 | Fewer than IW empty slots; dispatch is refused |
| bc_vld | input | IW | Broadcast lane valid bits |
| bc_tag | input | IW*TAGW | Broadcast result tags |
| grant | input | WINSIZE | Per-slot grant from the selection logic |
| issue_req | output | WINSIZE | Per-slot issue request |

## Verification
The bench builds the window with WINSIZE=4, IW=2 and TAGW=4. With only four slots, two dispatches fill half the window. One more instruction raises the full flag, so refused dispatch is reached within a few cycles. Two lanes per side are enough to show a wakeup arriving on either lane, a lane whose valid bit is low, and a second dispatch lane skipping past occupied slots. Four-bit tags keep every expected match easy to work out by hand.

// File: rtl/wk_pkg.sv
package wk_pkg;

  // source operands held by each window slot
  localparam int unsigned OPS = 2;

  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wk_tag_cmp.sv
module wk_tag_cmp
  import wk_pkg::*;
#(
  parameter int unsigned IW   = 4,
  parameter int unsigned TAGW = 7
) (
  input  logic [OPS*TAGW-1:0] src,
  input  logic [IW-1:0]       bc_vld,
  input  logic [IW*TAGW-1:0]  bc_tag,
  output logic [OPS-1:0]      hit
);

  // one comparator per operand per broadcast lane, ORed per operand
  for (genvar op = 0; op < OPS; op++) begin : g_op
    logic [IW-1:0] eq;
    for (genvar ln = 0; ln < IW; ln++) begin : g_ln
      assign eq[ln] = bc_vld[ln] &&
                      (src[op*TAGW +: TAGW] == bc_tag[ln*TAGW +: TAGW]);
    end
    assign hit[op] = |eq;
  end

endmodule

// File: rtl/wk_slot_alloc.sv
module wk_slot_alloc
  import wk_pkg::*;
#(
  parameter int unsigned WINSIZE = 16,
  parameter int unsigned IW      = 4,
  localparam int unsigned LW     = idx_w(IW),
  localparam int unsigned CW     = $clog2(WINSIZE + 1)
) (
  input  logic [WINSIZE-1:0]    busy,
  output logic [WINSIZE-1:0]    take,
  output logic [WINSIZE*LW-1:0] lane_of,
  output logic                  full
);

  logic [CW-1:0] free_cnt;

  // k-th empty slot from the bottom is paired with dispatch lane k
  always_comb begin
    int unsigned cnt;
    cnt     = 0;
    take    = '0;
    lane_of = '0;
    for (int unsigned i = 0; i < WINSIZE; i++) begin
      if (!busy[i] && cnt < IW) begin
        take[i]               = 1'b1;
        lane_of[i*LW +: LW]   = LW'(cnt);
        cnt                   = cnt + 1;
      end
    end
  end

  assign free_cnt = CW'($countones(~busy));
  assign full     = (free_cnt < CW'(IW));

endmodule

// File: rtl/wk_window.sv
module wk_window
  import wk_pkg::*;
#(
  parameter int unsigned WINSIZE = 16,
  parameter int unsigned IW      = 4,
  parameter int unsigned TAGW    = 7,
  localparam int unsigned LW     = idx_w(IW),
  localparam int unsigned SW     = OPS * TAGW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IW-1:0]        disp_vld,
  input  logic [IW*TAGW-1:0]   disp_src_a,
  input  logic [IW*TAGW-1:0]   disp_src_b,
  input  logic [IW-1:0]        disp_rdy_a,
  input  logic [IW-1:0]        disp_rdy_b,
  output logic                 disp_full,
  input  logic [IW-1:0]        bc_vld,
  input  logic [IW*TAGW-1:0]   bc_tag,
  input  logic [WINSIZE-1:0]   grant,
  output logic [WINSIZE-1:0]   issue_req
);

  logic [WINSIZE-1:0]    valid_q;
  logic [OPS-1:0]        rdy_q   [WINSIZE];
  logic [SW-1:0]         src_q   [WINSIZE];
  logic [OPS-1:0]        rdy_now [WINSIZE];
  logic [SW-1:0]         d_src   [IW];
  logic [OPS-1:0]        d_rdy   [IW];
  logic [WINSIZE-1:0]    take;
  logic [WINSIZE*LW-1:0] lane_of;
  logic [WINSIZE-1:0]    wr_mask;
  logic [WINSIZE-1:0]    rdy_a_vec;

  // incoming lanes: match against this cycle's broadcast too (R7)
  for (genvar l = 0; l < IW; l++) begin : g_disp
    logic [OPS-1:0] dhit;
    assign d_src[l] = {disp_src_b[l*TAGW +: TAGW], disp_src_a[l*TAGW +: TAGW]};
    wk_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp (
      .src(d_src[l]), .bc_vld(bc_vld), .bc_tag(bc_tag), .hit(dhit)
    );
    assign d_rdy[l] = {disp_rdy_b[l], disp_rdy_a[l]} | dhit;
  end

  wk_slot_alloc #(.WINSIZE(WINSIZE), .IW(IW)) u_alloc (
    .busy(valid_q), .take(take), .lane_of(lane_of), .full(disp_full)
  );

  // per-slot match row; request leaves in the wakeup cycle
  for (genvar i = 0; i < WINSIZE; i++) begin : g_slot
    logic [OPS-1:0] hit;
    logic [LW-1:0]  ln;
    wk_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp (
      .src(src_q[i]), .bc_vld(bc_vld), .bc_tag(bc_tag), .hit(hit)
    );
    assign rdy_now[i]   = rdy_q[i] | hit;
    assign issue_req[i] = valid_q[i] & (&rdy_now[i]);
    assign ln           = lane_of[i*LW +: LW];
    assign wr_mask[i]   = take[i] & disp_vld[ln] & ~disp_full;
    assign rdy_a_vec[i] = rdy_q[i][0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < WINSIZE; i++) rdy_q[i] <= '0;
    end else begin
      for (int i = 0; i < WINSIZE; i++) begin
        if (wr_mask[i]) begin
          valid_q[i] <= 1'b1;
          rdy_q[i]   <= d_rdy[lane_of[i*LW +: LW]];
        end else begin
          if (grant[i]) valid_q[i] <= 1'b0;
          rdy_q[i] <= rdy_now[i];
        end
      end
    end
  end

  // tag storage carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < WINSIZE; i++)
      if (wr_mask[i]) src_q[i] <= d_src[lane_of[i*LW +: LW]];
  end

endmodule

// File: rtl/wk_window_chk.sv
module wk_window_chk #(
  parameter int unsigned WINSIZE = 16,
  parameter int unsigned IW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [WINSIZE-1:0] grant,
  input logic [WINSIZE-1:0] issue_req,
  input logic               disp_full,
  input logic [WINSIZE-1:0] valid_q,
  input logic [WINSIZE-1:0] rdy_a,
  input logic [WINSIZE-1:0] wr_mask
);

  // R2: only occupied slots request
  a_r2_req_needs_entry: assert property (@(posedge clk) disable iff (rst)
    (issue_req & ~valid_q) == '0);

  // R3: a woken operand of a surviving slot stays ready
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(valid_q & rdy_a & ~grant & ~wr_mask) & ~rdy_a) == '0));

  // R6: at most IW slots written, never an occupied one
  a_r6_lane_limit: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr_mask) <= IW) && ((wr_mask & valid_q) == '0));

  // R9: a granted requester is gone next cycle
  a_r9_grant_frees: assert property (@(posedge clk) disable iff (rst)
    (|(grant & issue_req)) |=> ((issue_req & $past(grant & issue_req)) == '0));

  // R10: no write while the window reports full
  a_r10_full_blocks: assert property (@(posedge clk) disable iff (rst)
    disp_full |-> (wr_mask == '0));

endmodule

bind wk_window wk_window_chk #(.WINSIZE(WINSIZE), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .issue_req(issue_req),
  .disp_full(disp_full), .valid_q(valid_q), .rdy_a(rdy_a_vec),
  .wr_mask(wr_mask)
);

// File: tb/wk_window_test.sv
module wk_window_test;

  localparam int W = 4;
  localparam int I = 2;
  localparam int T = 4;
  localparam int NV = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [I-1:0]   disp_vld = '0;
  logic [I*T-1:0] disp_src_a = '0, disp_src_b = '0;
  logic [I-1:0]   disp_rdy_a = '0, disp_rdy_b = '0;
  logic           disp_full;
  logic [I-1:0]   bc_vld = '0;
  logic [I*T-1:0] bc_tag = '0;
  logic [W-1:0]   grant = '0;
  logic [W-1:0]   issue_req;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  wk_window #(.WINSIZE(W), .IW(I), .TAGW(T)) uut (
    .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_src_a(disp_src_a),
    .disp_src_b(disp_src_b), .disp_rdy_a(disp_rdy_a), .disp_rdy_b(disp_rdy_b),
    .disp_full(disp_full), .bc_vld(bc_vld), .bc_tag(bc_tag),
    .grant(grant), .issue_req(issue_req)
  );

  // row: dv ta0 tb0 ta1 tb1 ra rb bv bt0 bt1 gnt exp_req exp_full
  localparam logic [40:0] VEC [NV] = '{
    {2'b11, 4'd1, 4'd2, 4'd3, 4'd4, 2'b10, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0000, 4'b0000, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b01, 4'd4, 4'd0, 4'b0000, 4'b0010, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0000, 4'b0010, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b10, 4'd2, 4'd1, 4'b0000, 4'b0010, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b01, 4'd2, 4'd0, 4'b0010, 4'b0011, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0001, 4'b0001, 1'b0},
    {2'b10, 4'd0, 4'd0, 4'd5, 4'd6, 2'b10, 2'b10, 2'b01, 4'd5, 4'd0, 4'b0000, 4'b0000, 1'b0},
    {2'b11, 4'd7, 4'd8, 4'd9, 4'd10, 2'b00, 2'b00, 2'b11, 4'd7, 4'd8, 4'b0000, 4'b0010, 1'b0},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0000, 4'b0011, 1'b1},
    {2'b01, 4'd11, 4'd12, 4'd0, 4'd0, 2'b01, 2'b01, 2'b11, 4'd9, 4'd10, 4'b0000, 4'b0111, 1'b1},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0111, 4'b0111, 1'b1},
    {2'b00, 4'd0, 4'd0, 4'd0, 4'd0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'b0000, 4'b0000, 1'b0}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R8 dispatch pair";
      1: return "R5 lane0 wakes second operand";
      2: return "R3 ready persists";
      3: return "R4 invalid lane ignored";
      4: return "R5 wake and R2 request";
      5: return "R9 grant empties slot";
      6: return "R6 lane1 to second empty slot";
      7: return "R7 same-cycle wake at dispatch";
      8: return "R10 full raised";
      9: return "R10 dispatch dropped while full";
      10: return "R10 dropped lane left slot empty";
      default: return "R9 window drained";
    endcase
  endfunction

  task automatic check(input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic idle();
    disp_vld = '0; bc_vld = '0; grant = '0;
    disp_rdy_a = '0; disp_rdy_b = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [40:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset issue_req", issue_req, '0);
    check("R1 reset disp_full", {3'b0, disp_full}, '0);

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      v = VEC[r];
      disp_vld   = v[40:39];
      disp_src_a = {v[30:27], v[38:35]};
      disp_src_b = {v[26:23], v[34:31]};
      disp_rdy_a = v[22:21];
      disp_rdy_b = v[20:19];
      bc_vld     = v[18:17];
      bc_tag     = {v[12:9], v[16:13]};
      grant      = v[8:5];
      #1;
      check({row_tag(r), " req"}, issue_req, v[4:1]);
      check({row_tag(r), " full"}, {3'b0, disp_full}, {3'b0, v[0]});
    end

    // directed: invalid tag equal to sources, then one tag wakes both
    @(negedge clk);
    idle();
    disp_vld = 2'b01; disp_src_a = {4'd0, 4'd3}; disp_src_b = {4'd0, 4'd3};
    @(negedge clk);
    idle();
    bc_vld = 2'b00; bc_tag = {4'd3, 4'd3};
    #1;
    check("R4 low valid bits wake nothing", issue_req, 4'b0000);
    @(negedge clk);
    idle();
    bc_vld = 2'b10; bc_tag = {4'd3, 4'd0};
    #1;
    check("R5 one tag on lane1 wakes both operands", issue_req, 4'b0001);
    @(negedge clk);
    idle();
    #1;
    check("R3 both operands stay ready", issue_req, 4'b0001);

    // directed: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 mid-run reset issue_req", issue_req, '0);
    check("R1 mid-run reset disp_full", {3'b0, disp_full}, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule